// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor with six operating modes: user, fast interrupt, normal interrupt, supervisor, abort and undefined. Software names registers with a 4-bit logical index. The current mode decides which physical copy that index selects. Indices 0 to 7 and index 15, the program counter, are the same register in every mode. Indices 13 and 14 have a private copy in each exception mode. The fast interrupt mode also has private copies of indices 8 to 12. Altogether there are 31 physical general-purpose registers.

The block holds the current status word. The mode is taken from its low five bits. It also holds one saved status word for each of the five exception modes. There are two combinational read ports and one write port that takes effect at the clock edge. The current status word has its own write path, and so does the saved status word of the current mode.

A one-cycle exception-entry request with a target mode does three things at a single clock edge. It saves the current status into the target's saved status. It loads a supplied return address into the target's register 14. It switches the mode field to the target.

Top module: `banked_regfile`

## Requirements
- R1: After reset the current status reads 0x00000013 (supervisor), and every register and saved status reads zero.
- R2: Logical indices 0 to 7 and 15 name one shared copy: a value written in any mode reads back unchanged in every other mode.
- R3: Indices 13 and 14 select a private copy in each of the fast interrupt, normal interrupt, supervisor, abort and undefined modes. Indices 8 to 12 are shared by all modes other than fast interrupt.
- R4: In fast interrupt mode, indices 8 to 14 select copies private to that mode. Other modes see their own values at indices 8 to 12.
- R5: The mode field is bits [4:0] of the current status, with user=10000, fast interrupt=10001, normal interrupt=10010, supervisor=10011, abort=10111 and undefined=11011. Any other value behaves exactly as user mode.
- R6: A register write made in one mode leaves every banked copy that belongs to another mode unchanged.
- R7: The saved status port reads and writes the saved status of the current exception mode only. Each exception mode keeps its own value.
- R8: In user mode the saved status port reads zero and its writes are dropped.
- R9: An exception-entry request with a valid exception target does three things at one edge. It copies the whole current status into the target's saved status. It writes the return address to the target's index 14. It sets status bits [4:0] to the target code and leaves the other bits unchanged.
- R10: While the exception-entry request is high, the register, status and saved-status writes of that cycle are dropped. A request whose target code is user or an undefined code changes nothing.
- R11: A read of the register being written in the same cycle returns the value held before the edge.
- R12: The current status write replaces the whole status word. Reads after it use the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Logical index of read port A |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_idx | input | 4 | Logical index of read port B |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical index of the register write |
| wr_data | input | 32 | Register write data |
| st_wr_en | input | 1 | Current status write enable |
| st_wr_data | input | 32 | New current status word |
| cur_status | output | 32 | Current status word |
| sv_wr_en | input | 1 | Saved status write enable, current mode |
| sv_wr_data | input | 32 | Saved status write data |
| sv_rd_data | output | 32 | Saved status of the current mode, zero in user mode |
| exc_en | input | 1 | Exception-entry request, one cycle |
| exc_mode | input | 5 | Target mode code of the exception entry |
| exc_ret | input | 32 | Return address loaded into the target's index 14 |

## Verification
The assertions assume that every input is driven to a known value while reset is released. They also assume that an exception request's target code and return address stay stable for the cycle in which they are sampled. The bench meets both assumptions. It holds every enable low during reset and changes inputs only on the falling clock edge, so each operation occupies exactly one full cycle. Mode changes are made only through the status write or a valid exception entry. The one exception is a single deliberate out-of-range mode code, which tests the rule that such a code behaves as user mode.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

    localparam int LIDX_W    = 4;
    localparam int MODE_W    = 5;
    localparam int NUM_PHYS  = 31;
    localparam int NUM_SAVED = 5;
    localparam int PHYS_W    = $clog2(NUM_PHYS);
    localparam int SLOT_W    = $clog2(NUM_SAVED);

    // mode field codes held in status bits [4:0]
    localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MD_UND = 5'b11011;

    // physical layout: 0-7 shared, 8-14 user, 15 program counter,
    // 16-22 fast interrupt 8-14, then pairs of 13/14 per exception mode
    localparam logic [PHYS_W-1:0] PB_FIQ = 5'd16;
    localparam logic [PHYS_W-1:0] PB_IRQ = 5'd23;
    localparam logic [PHYS_W-1:0] PB_SVC = 5'd25;
    localparam logic [PHYS_W-1:0] PB_ABT = 5'd27;
    localparam logic [PHYS_W-1:0] PB_UND = 5'd29;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    function automatic logic [PHYS_W-1:0] phys_of(input logic [LIDX_W-1:0] idx,
                                                   input bank_e bk);
        logic [PHYS_W-1:0] p;
        logic [PHYS_W-1:0] off8;
        logic [PHYS_W-1:0] off13;
        p     = PHYS_W'(idx);
        off8  = PHYS_W'(idx) - PHYS_W'(8);
        off13 = PHYS_W'(idx) - PHYS_W'(13);
        if (bk == BK_FIQ && idx >= 4'd8 && idx <= 4'd14) begin
            p = PB_FIQ + off8;
        end else if (idx == 4'd13 || idx == 4'd14) begin
            case (bk)
                BK_IRQ:  p = PB_IRQ + off13;
                BK_SVC:  p = PB_SVC + off13;
                BK_ABT:  p = PB_ABT + off13;
                BK_UND:  p = PB_UND + off13;
                default: p = PHYS_W'(idx);
            endcase
        end
        return p;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input bank_e bk);
        logic [SLOT_W-1:0] s;
        case (bk)
            BK_FIQ:  s = 3'd0;
            BK_IRQ:  s = 3'd1;
            BK_SVC:  s = 3'd2;
            BK_ABT:  s = 3'd3;
            BK_UND:  s = 3'd4;
            default: s = 3'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
    import bankrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_field,
    output bank_e             bank,
    output logic              is_exc
);

    always_comb begin
        case (mode_field)
            MD_FIQ:  bank = BK_FIQ;
            MD_IRQ:  bank = BK_IRQ;
            MD_SVC:  bank = BK_SVC;
            MD_ABT:  bank = BK_ABT;
            MD_UND:  bank = BK_UND;
            default: bank = BK_USR;
        endcase
        is_exc = (bank != BK_USR);
    end

endmodule

// File: rtl/rf_index_map.sv
module rf_index_map
    import bankrf_pkg::*;
(
    input  logic [LIDX_W-1:0] lidx,
    input  bank_e             bank,
    output logic [PHYS_W-1:0] pidx
);

    assign pidx = phys_of(lidx, bank);

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              st_wr_en,
    input  logic [DATA_W-1:0] st_wr_data,
    output logic [DATA_W-1:0] cur_status,
    input  logic              sv_wr_en,
    input  logic [DATA_W-1:0] sv_wr_data,
    output logic [DATA_W-1:0] sv_rd_data,
    input  logic              exc_en,
    input  logic [4:0]        exc_mode,
    input  logic [DATA_W-1:0] exc_ret
);

    localparam int NUM_PORTS = 3;   // read A, read B, write
    localparam int LR_IDX    = 14;

    typedef struct packed {
        logic [NUM_PHYS-1:0][DATA_W-1:0]  gpr;
        logic [NUM_SAVED-1:0][DATA_W-1:0] sav;
        logic [DATA_W-1:0]                cur;
    } state_t;

    localparam state_t RST_STATE = '{gpr: '0, sav: '0, cur: DATA_W'(MD_SVC)};

    state_t st_d, st_q;

    bank_e cur_bank, exc_bank;
    logic  cur_exc, exc_ok;

    rf_mode_decode u_cur_dec (
        .mode_field (st_q.cur[MODE_W-1:0]),
        .bank       (cur_bank),
        .is_exc     (cur_exc)
    );

    rf_mode_decode u_exc_dec (
        .mode_field (exc_mode),
        .bank       (exc_bank),
        .is_exc     (exc_ok)
    );

    logic [NUM_PORTS-1:0][LIDX_W-1:0] map_lidx;
    logic [NUM_PORTS-1:0][PHYS_W-1:0] map_pidx;

    assign map_lidx = {wr_idx, rd_b_idx, rd_a_idx};

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_map
        rf_index_map u_map (
            .lidx (map_lidx[g]),
            .bank (cur_bank),
            .pidx (map_pidx[g])
        );
    end

    // reads see the registered state only: no write-to-read bypass
    assign rd_a_data  = st_q.gpr[map_pidx[0]];
    assign rd_b_data  = st_q.gpr[map_pidx[1]];
    assign cur_status = st_q.cur;
    assign sv_rd_data = cur_exc ? st_q.sav[slot_of(cur_bank)] : '0;

    always_comb begin
        st_d = st_q;
        if (exc_en) begin
            if (exc_ok) begin
                st_d.sav[slot_of(exc_bank)]                  = st_q.cur;
                st_d.gpr[phys_of(LIDX_W'(LR_IDX), exc_bank)] = exc_ret;
                st_d.cur[MODE_W-1:0]                         = exc_mode;
            end
        end else begin
            if (wr_en) begin
                st_d.gpr[map_pidx[2]] = wr_data;
            end
            if (st_wr_en) begin
                st_d.cur = st_wr_data;
            end
            if (sv_wr_en && cur_exc) begin
                st_d.sav[slot_of(cur_bank)] = sv_wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    AST_SHARED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !exc_en && wr_idx < 4'd8) |=> (st_q.gpr[$past(wr_idx)] == $past(wr_data))); // R2

    AST_FIQ_COPY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !exc_en && cur_bank != BK_FIQ) |=> (st_q.gpr[PB_FIQ] == $past(st_q.gpr[PB_FIQ]))); // R6

    AST_USR_SAVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bank == BK_USR) |-> (sv_rd_data == '0)); // R8

    AST_EXC_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && exc_ok) |=> (st_q.sav[slot_of($past(exc_bank))] == $past(cur_status))); // R9

    AST_EXC_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && exc_ok) |=> (st_q.gpr[phys_of(LIDX_W'(LR_IDX), $past(exc_bank))] == $past(exc_ret))); // R9

    AST_EXC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && exc_ok) |=> (cur_status[MODE_W-1:0] == $past(exc_mode))); // R9

    AST_EXC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && !exc_ok) |=> $stable(st_q)); // R10

endmodule

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;

    localparam logic [3:0] OP_WR  = 4'd0;
    localparam logic [3:0] OP_RDA = 4'd1;
    localparam logic [3:0] OP_RDB = 4'd2;
    localparam logic [3:0] OP_ST  = 4'd3;
    localparam logic [3:0] OP_SVW = 4'd4;
    localparam logic [3:0] OP_SVR = 4'd5;
    localparam logic [3:0] OP_CS  = 4'd6;
    localparam logic [3:0] OP_EXC = 4'd7;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  idx;
        logic [31:0] arg;
        logic [31:0] expv;   // expected value, or return address for OP_EXC
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 55;
    localparam vec_t VECS [NV] = '{
        '{OP_CS,  4'd0,  32'h0,        32'h13,       4'd1},  // R1
        '{OP_RDA, 4'd5,  32'h0,        32'h0,        4'd1},  // R1
        '{OP_SVR, 4'd0,  32'h0,        32'h0,        4'd1},  // R1
        '{OP_ST,  4'd0,  32'h10,       32'h0,        4'd12}, // R12
        '{OP_CS,  4'd0,  32'h0,        32'h10,       4'd12}, // R12
        '{OP_WR,  4'd0,  32'hA0,       32'h0,        4'd2},  // R2
        '{OP_WR,  4'd8,  32'h08000008, 32'h0,        4'd3},  // R3
        '{OP_WR,  4'd13, 32'h13000000, 32'h0,        4'd3},  // R3
        '{OP_WR,  4'd14, 32'h14000000, 32'h0,        4'd3},  // R3
        '{OP_WR,  4'd15, 32'hF0,       32'h0,        4'd2},  // R2
        '{OP_SVW, 4'd0,  32'hDEAD,     32'h0,        4'd8},  // R8
        '{OP_SVR, 4'd0,  32'h0,        32'h0,        4'd8},  // R8
        '{OP_ST,  4'd0,  32'h11,       32'h0,        4'd4},  // R4
        '{OP_RDA, 4'd0,  32'h0,        32'hA0,       4'd2},  // R2
        '{OP_RDB, 4'd15, 32'h0,        32'hF0,       4'd2},  // R2
        '{OP_RDA, 4'd8,  32'h0,        32'h0,        4'd4},  // R4
        '{OP_WR,  4'd8,  32'h88,       32'h0,        4'd4},  // R4
        '{OP_WR,  4'd13, 32'hF13,      32'h0,        4'd4},  // R4
        '{OP_RDA, 4'd8,  32'h0,        32'h88,       4'd4},  // R4
        '{OP_RDB, 4'd13, 32'h0,        32'hF13,      4'd4},  // R4
        '{OP_SVW, 4'd0,  32'h1111,     32'h0,        4'd7},  // R7
        '{OP_SVR, 4'd0,  32'h0,        32'h1111,     4'd7},  // R7
        '{OP_ST,  4'd0,  32'h12,       32'h0,        4'd3},  // R3
        '{OP_RDA, 4'd8,  32'h0,        32'h08000008, 4'd4},  // R4
        '{OP_RDB, 4'd13, 32'h0,        32'h0,        4'd3},  // R3
        '{OP_WR,  4'd13, 32'h213,      32'h0,        4'd3},  // R3
        '{OP_WR,  4'd14, 32'h214,      32'h0,        4'd3},  // R3
        '{OP_SVR, 4'd0,  32'h0,        32'h0,        4'd7},  // R7
        '{OP_ST,  4'd0,  32'h10,       32'h0,        4'd6},  // R6
        '{OP_RDA, 4'd13, 32'h0,        32'h13000000, 4'd6},  // R6
        '{OP_RDB, 4'd14, 32'h0,        32'h14000000, 4'd6},  // R6
        '{OP_RDA, 4'd8,  32'h0,        32'h08000008, 4'd6},  // R6
        '{OP_ST,  4'd0,  32'h11,       32'h0,        4'd6},  // R6
        '{OP_RDA, 4'd13, 32'h0,        32'hF13,      4'd6},  // R6
        '{OP_SVR, 4'd0,  32'h0,        32'h1111,     4'd7},  // R7
        '{OP_ST,  4'd0,  32'h1F,       32'h0,        4'd5},  // R5
        '{OP_RDA, 4'd13, 32'h0,        32'h13000000, 4'd5},  // R5
        '{OP_SVR, 4'd0,  32'h0,        32'h0,        4'd5},  // R5
        '{OP_ST,  4'd0,  32'h10,       32'h0,        4'd9},  // R9
        '{OP_EXC, 4'd0,  32'h17,       32'hABC,      4'd9},  // R9
        '{OP_CS,  4'd0,  32'h0,        32'h17,       4'd9},  // R9
        '{OP_SVR, 4'd0,  32'h0,        32'h10,       4'd9},  // R9
        '{OP_RDA, 4'd14, 32'h0,        32'hABC,      4'd9},  // R9
        '{OP_EXC, 4'd0,  32'h10,       32'h999,      4'd10}, // R10
        '{OP_CS,  4'd0,  32'h0,        32'h17,       4'd10}, // R10
        '{OP_RDA, 4'd14, 32'h0,        32'hABC,      4'd10}, // R10
        '{OP_EXC, 4'd0,  32'h1B,       32'h55,       4'd9},  // R9
        '{OP_CS,  4'd0,  32'h0,        32'h1B,       4'd9},  // R9
        '{OP_SVR, 4'd0,  32'h0,        32'h17,       4'd9},  // R9
        '{OP_RDB, 4'd14, 32'h0,        32'h55,       4'd9},  // R9
        '{OP_RDA, 4'd13, 32'h0,        32'h0,        4'd3},  // R3
        '{OP_ST,  4'd0,  32'h12,       32'h0,        4'd6},  // R6
        '{OP_RDA, 4'd14, 32'h0,        32'h214,      4'd6},  // R6
        '{OP_ST,  4'd0,  32'h13,       32'h0,        4'd3},  // R3
        '{OP_RDA, 4'd14, 32'h0,        32'h0,        4'd3}   // R3
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data, st_wr_data, cur_status;
    logic [31:0] sv_wr_data, sv_rd_data, exc_ret;
    logic        wr_en, st_wr_en, sv_wr_en, exc_en;
    logic [4:0]  exc_mode;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    banked_regfile dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (rd_a_idx),
        .rd_a_data  (rd_a_data),
        .rd_b_idx   (rd_b_idx),
        .rd_b_data  (rd_b_data),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .st_wr_en   (st_wr_en),
        .st_wr_data (st_wr_data),
        .cur_status (cur_status),
        .sv_wr_en   (sv_wr_en),
        .sv_wr_data (sv_wr_data),
        .sv_rd_data (sv_rd_data),
        .exc_en     (exc_en),
        .exc_mode   (exc_mode),
        .exc_ret    (exc_ret)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] got, input logic [31:0] expv);
        n_run++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, expv);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; st_wr_en = 1'b0; sv_wr_en = 1'b0; exc_en = 1'b0;
        wr_idx = '0; wr_data = '0; st_wr_data = '0; sv_wr_data = '0;
        exc_mode = '0; exc_ret = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        idle_inputs();
        case (v.op)
            OP_WR:  begin wr_en = 1'b1; wr_idx = v.idx; wr_data = v.arg; end
            OP_ST:  begin st_wr_en = 1'b1; st_wr_data = v.arg; end
            OP_SVW: begin sv_wr_en = 1'b1; sv_wr_data = v.arg; end
            OP_EXC: begin exc_en = 1'b1; exc_mode = v.arg[4:0]; exc_ret = v.expv; end
            OP_RDA: rd_a_idx = v.idx;
            OP_RDB: rd_b_idx = v.idx;
            default: ;
        endcase
        #1;
        case (v.op)
            OP_RDA: check(int'(v.req), "read A", rd_a_data, v.expv);
            OP_RDB: check(int'(v.req), "read B", rd_b_data, v.expv);
            OP_SVR: check(int'(v.req), "saved status", sv_rd_data, v.expv);
            OP_CS:  check(int'(v.req), "current status", cur_status, v.expv);
            default: ;
        endcase
    endtask

    initial begin
        rst_n = 1'b0;
        rd_a_idx = '0;
        rd_b_idx = '0;
        idle_inputs();
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state seen while reset is held
        check(1, "status in reset", cur_status, 32'h13);
        check(1, "read A in reset", rd_a_data, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
        end

        // R11: same-cycle read of the register being written sees the old value
        @(negedge clk);
        idle_inputs();
        wr_en = 1'b1; wr_idx = 4'd1; wr_data = 32'h77;
        rd_a_idx = 4'd1;
        #1;
        check(11, "read during write", rd_a_data, 32'h0);
        @(negedge clk);
        idle_inputs();
        #1;
        check(11, "read after write", rd_a_data, 32'h77);

        // R10: exception entry drops the other writes of the same cycle
        @(negedge clk);
        idle_inputs();
        exc_en = 1'b1; exc_mode = 5'b10010; exc_ret = 32'h3;
        wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'h99;
        st_wr_en = 1'b1; st_wr_data = 32'h11;
        @(negedge clk);
        idle_inputs();
        rd_a_idx = 4'd0;
        rd_b_idx = 4'd14;
        #1;
        check(10, "status after combined entry", cur_status, 32'h12);
        check(10, "shared reg after combined entry", rd_a_data, 32'hA0);
        check(9, "link after combined entry", rd_b_data, 32'h3);
        check(9, "saved after combined entry", sv_rd_data, 32'h13);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule